// File: doc/BRIEF.md
# Six-Channel Gate Enable Controller with Short-Circuit Latch

This block sits between a serial control register, a set of real-time parallel command pins and six low-side gate pre-drivers. For each channel it merges the two command sources, so the gate enable is on whenever either source asks for it. The parallel pins act without any clock edge on the serial side. The gate enable is a combinational function of the command pins and one trip register, so a parallel command reaches the gate in the same cycle.

Each channel also watches a shorted-load detect input and an open-load detect input. A short seen while the gate is on trips the channel and turns the gate off. An open load only raises the fault flag. A per-channel build-time mask selects the recovery style. A latching channel stays off until one of its command paths drops and is then raised again. An auto-retry channel turns its gate back on after a fixed number of clock cycles, and keeps its flag set until a retry finds the load healthy.

The six fault flags are packed with the battery over-voltage and under-voltage inputs into one readback word for the serial shifter to capture. Every pin is a plain control or status level. No data stream passes through the block, so it has no valid/ready handshake and applies no back-pressure.

Top module: `gate_ctl_bank`

## Requirements
- R1: For each channel, with no trip active, `gate_en[i]` equals `ser_on[i] | par_on[i]` in the same cycle, with no clock edge needed.
- R2: A channel that is tripped holds `gate_en[i]` low whatever its commands are, and channels that are not tripped are unaffected by it.
- R3: `short_det[i]` high at a rising clock edge while `gate_en[i]` is high trips the channel. From just after that edge, `gate_en[i]` is low and `ch_fault[i]` is high.
- R4: A latching channel (mask bit 0) stays off while its commands are held high, even after `short_det[i]` returns low.
- R5: A latching trip is released at the first edge where `par_on[i]` is seen going from 1 to 0. The gate then follows the commands again.
- R6: A latching trip is also released at the first edge where `ser_on[i]` is seen going from 1 to 0. If the other path is still high, the gate comes back on right after that edge.
- R7: `short_det[i]` while `gate_en[i]` is low has no effect: the gate does not trip and no fault is raised.
- R8: An auto-retry channel (mask bit 1) keeps its gate off for exactly `RETRY_CYCLES` cycles after a trip. It then re-enables the gate with no change on the command pins.
- R9: The short part of `ch_fault[i]` clears at the first edge where `gate_en[i]` is high and `short_det[i]` is low. On an auto-retry channel it therefore stays set through retries into a persisting short.
- R10: `open_det[i]` sets `ch_fault[i]` one cycle later without turning the gate off, and the flag drops one cycle after `open_det[i]` falls.
- R11: `flag_word` carries `bat_over` in bit NUM_CH+1, `bat_under` in bit NUM_CH and `ch_fault[i]` in bit i. The high bits go first in the serial shift order.
- R12: After reset, with no detect input active, every `ch_fault` bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_on | input | NUM_CH | Per-channel command bits from the serial control register |
| par_on | input | NUM_CH | Per-channel real-time parallel command pins |
| short_det | input | NUM_CH | Shorted-load detect, one per channel |
| open_det | input | NUM_CH | Open-load detect, one per channel |
| bat_over | input | 1 | Battery over-voltage flag |
| bat_under | input | 1 | Battery under-voltage flag |
| gate_en | output | NUM_CH | Gate pre-driver enables |
| ch_fault | output | NUM_CH | Per-channel fault flags (short or open) |
| flag_word | output | NUM_CH+2 | Readback word for the serial shifter |

## Verification
Results arrive at three latencies. `gate_en` and `flag_word` follow their inputs in the same cycle. A trip, a release and any change of `ch_fault` appear just after the first rising edge that samples the stimulus. An auto-retry gate returns exactly `RETRY_CYCLES` edges after its trip. The bench changes inputs only on falling edges. It reads same-cycle results before the next rising edge, and reads registered results at the falling edge that follows the counted number of rising edges. The retry window is counted edge by edge, so a gate that comes back one cycle early or late is caught.

// File: rtl/gctl_pkg.sv
package gctl_pkg;

  typedef enum logic {
    REC_LATCH = 1'b0,
    REC_RETRY = 1'b1
  } recovery_e;

  // Recovery style for channel idx taken from a build-time mask
  function automatic recovery_e recovery_of(input logic [31:0] mask, input int idx);
    return mask[idx] ? REC_RETRY : REC_LATCH;
  endfunction

  // Width of a counter that must hold values 0 .. n-1
  function automatic int count_width(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/gctl_retry_timer.sv
module gctl_retry_timer #(
  parameter int CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);
  localparam int CW = gctl_pkg::count_width(CYCLES);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign expire = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (!run || expire)  cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/gctl_channel.sv
module gctl_channel #(
  parameter gctl_pkg::recovery_e MODE = gctl_pkg::REC_LATCH,
  parameter int RETRY_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_on,
  input  logic par_on,
  input  logic short_det,
  input  logic open_det,
  output logic gate_en,
  output logic fault
);
  logic trip_q;
  logic short_flag_q;
  logic open_q;
  logic release_now;
  logic trip_now;

  assign gate_en  = (ser_on | par_on) & ~trip_q;
  assign trip_now = gate_en & short_det;
  assign fault    = short_flag_q | open_q;

  generate
    if (MODE == gctl_pkg::REC_RETRY) begin : g_retry
      gctl_retry_timer #(.CYCLES(RETRY_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (trip_q),
        .expire (release_now)
      );
    end else begin : g_latch
      logic ser_q, par_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ser_q <= 1'b0;
          par_q <= 1'b0;
        end else begin
          ser_q <= ser_on;
          par_q <= par_on;
        end
      end
      assign release_now = trip_q & ((ser_q & ~ser_on) | (par_q & ~par_on));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trip_q       <= 1'b0;
      short_flag_q <= 1'b0;
      open_q       <= 1'b0;
    end else begin
      open_q <= open_det;
      if (trip_now)         trip_q <= 1'b1;
      else if (release_now) trip_q <= 1'b0;
      if (trip_now)                   short_flag_q <= 1'b1;
      else if (gate_en && !short_det) short_flag_q <= 1'b0;
    end
  end
endmodule

// File: rtl/gate_ctl_bank.sv
module gate_ctl_bank #(
  parameter int          NUM_CH       = 6,
  parameter int          RETRY_CYCLES = 64,
  parameter logic [31:0] RETRY_MASK   = 32'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] ser_on,
  input  logic [NUM_CH-1:0] par_on,
  input  logic [NUM_CH-1:0] short_det,
  input  logic [NUM_CH-1:0] open_det,
  input  logic              bat_over,
  input  logic              bat_under,
  output logic [NUM_CH-1:0] gate_en,
  output logic [NUM_CH-1:0] ch_fault,
  output logic [NUM_CH+1:0] flag_word
);
  localparam int WORD_W = NUM_CH + 2;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    gctl_channel #(
      .MODE         (gctl_pkg::recovery_of(RETRY_MASK, i)),
      .RETRY_CYCLES (RETRY_CYCLES)
    ) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .ser_on    (ser_on[i]),
      .par_on    (par_on[i]),
      .short_det (short_det[i]),
      .open_det  (open_det[i]),
      .gate_en   (gate_en[i]),
      .fault     (ch_fault[i])
    );
  end

  assign flag_word = WORD_W'({bat_over, bat_under, ch_fault});
endmodule

// File: rtl/gate_ctl_bank_chk.sv
module gate_ctl_bank_chk #(
  parameter int NUM_CH = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] ser_on,
  input logic [NUM_CH-1:0] par_on,
  input logic [NUM_CH-1:0] short_det,
  input logic [NUM_CH-1:0] open_det,
  input logic [NUM_CH-1:0] gate_en,
  input logic [NUM_CH-1:0] ch_fault
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    // R1
    gate_needs_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gate_en[i] |-> (ser_on[i] | par_on[i]));

    // R3
    short_trips_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_en[i] && short_det[i]) |=> (!gate_en[i] && ch_fault[i]));

    // R7
    idle_short_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!gate_en[i] && short_det[i] && !open_det[i] && !ch_fault[i]) |=> !ch_fault[i]);

    // R10
    open_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      open_det[i] |=> ch_fault[i]);
  end
endmodule

bind gate_ctl_bank gate_ctl_bank_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ser_on    (ser_on),
  .par_on    (par_on),
  .short_det (short_det),
  .open_det  (open_det),
  .gate_en   (gate_en),
  .ch_fault  (ch_fault)
);

// File: tb/test_gate_ctl_bank.sv
`timescale 1ns/1ps
module test_gate_ctl_bank;
  localparam int N     = 6;
  localparam int RETRY = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] ser_on = '0, par_on = '0, short_det = '0, open_det = '0;
  logic bat_over = 1'b0, bat_under = 1'b0;
  logic [N-1:0] gate_en, ch_fault;
  logic [N+1:0] flag_word;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gate_ctl_bank #(.NUM_CH(N), .RETRY_CYCLES(RETRY), .RETRY_MASK(32'h38)) i_gate_ctl_bank (
    .clk(clk), .rst_n(rst_n), .ser_on(ser_on), .par_on(par_on),
    .short_det(short_det), .open_det(open_det), .bat_over(bat_over),
    .bat_under(bat_under), .gate_en(gate_en), .ch_fault(ch_fault),
    .flag_word(flag_word)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick();
    // R12 reset state
    check("R12 faults after reset", ch_fault, 0);
    check("R12 gates idle", gate_en, 0);

    // R1 exhaustive OR sweep, same cycle
    for (int s = 0; s < 64; s++) begin
      for (int p = 0; p < 64; p++) begin
        ser_on = s[N-1:0];
        par_on = p[N-1:0];
        #1;
        check("R1 gate is OR of commands", gate_en, s | p);
        @(negedge clk);
      end
    end
    ser_on = '0; par_on = '0;

    // R7 shorts while off are ignored
    short_det = '1;
    tick(2);
    check("R7 no fault from idle short", ch_fault, 0);
    short_det = '0;
    tick();
    check("R7 gates still follow command", gate_en, 0);

    // R3 / R4 / R5 latching channel 0 via parallel path
    par_on[0] = 1'b1; ser_on[5:1] = 5'b10101;
    tick();
    check("R1 ch0 on", gate_en[0], 1);
    short_det[0] = 1'b1;
    tick();
    check("R3 gate off after short", gate_en[0], 0);
    check("R3 fault set after short", ch_fault[0], 1);
    check("R2 others unaffected", gate_en[5:1], 5'b10101);
    short_det[0] = 1'b0;
    tick(3);
    check("R4 stays off while held", gate_en[0], 0);
    check("R4 fault held", ch_fault[0], 1);
    par_on[0] = 1'b0;
    tick();
    check("R5 off while par low", gate_en[0], 0);
    par_on[0] = 1'b1;
    #1;
    check("R5 re-enabled on rise", gate_en[0], 1);
    tick();
    check("R9 latched fault cleared by healthy run", ch_fault[0], 0);
    par_on[0] = 1'b0; ser_on = '0;
    tick();

    // R6 serial path release, parallel still high
    ser_on[1] = 1'b1; par_on[1] = 1'b1;
    tick();
    short_det[1] = 1'b1;
    tick();
    check("R6 tripped", gate_en[1], 0);
    short_det[1] = 1'b0;
    tick(2);
    check("R2 trip overrides both commands", gate_en[1], 0);
    ser_on[1] = 1'b0;
    tick();
    check("R6 released by serial fall", gate_en[1], 1);
    tick();
    check("R6 fault cleared", ch_fault[1], 0);
    par_on[1] = 1'b0;
    tick();

    // R8 / R9 auto-retry channel 3
    par_on[3] = 1'b1;
    tick();
    short_det[3] = 1'b1;
    tick();
    check("R8 off after trip", gate_en[3], 0);
    tick(RETRY - 1);
    check("R8 still off before window end", gate_en[3], 0);
    tick();
    check("R8 retried after window", gate_en[3], 1);
    check("R9 flag held during retry", ch_fault[3], 1);
    tick();
    check("R8 retrip on persisting short", gate_en[3], 0);
    short_det[3] = 1'b0;
    tick(RETRY - 1);
    check("R9 flag held while off", ch_fault[3], 1);
    check("R8 off in second window", gate_en[3], 0);
    tick();
    check("R8 second retry on", gate_en[3], 1);
    tick();
    check("R9 flag clears after healthy retry", ch_fault[3], 0);
    check("R8 stays on", gate_en[3], 1);
    par_on[3] = 1'b0;
    tick();

    // R10 open load
    par_on[2] = 1'b1; open_det[2] = 1'b1;
    #1;
    check("R10 no flag before edge", ch_fault[2], 0);
    tick();
    check("R10 flag after one edge", ch_fault[2], 1);
    check("R10 gate stays on", gate_en[2], 1);
    open_det[2] = 1'b0;
    tick();
    check("R10 flag drops", ch_fault[2], 0);
    par_on[2] = 1'b0;

    // R11 readback word layout, swept over supply flags
    open_det = 6'b010010;
    tick();
    for (int v = 0; v < 4; v++) begin
      bat_over = v[1]; bat_under = v[0];
      #1;
      check("R11 word layout", flag_word, (v << N) | 6'b010010);
      @(negedge clk);
    end
    open_det = '0;
    tick();
    check("R12 all flags clear again", ch_fault, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule